// File: doc/BRIEF.md
# Clock Source Switching Controller

This block decides which oscillator clocks a small controller. After reset it runs from the on-chip oscillator. When software sets the external-enable bit in its clock configuration register, the switch starts. The block gates all chip clocks and halts the CPU. It turns the on-chip oscillator off and the external resonator or crystal on. It then waits for an external-stable indication.

Once the external clock is stable, the block opens the clock gate. It keeps the CPU halted for a resume delay, counted in microsecond ticks, and then releases it. The switch runs one way only. Clearing the enable bit while on the external clock changes nothing. The stored bit is looked at again only when the chip wakes from suspend, and it then chooses the clock source for the wake.

The block also drives the level on the oscillator output pin. In internal mode, the oscillator input pin works as a general-purpose input, and its level can be read at a port address. The analog oscillators, the glitch-free clock multiplexer and oscillator tuning live outside this block.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset the block is in internal run: sel_ext_o=0, int_osc_en_o=1, ext_osc_en_o=0, clk_gate_en_o=1, cpu_run_o=1, timeout_o=0, and the configuration register reads 0. The two oscillator enables are never both 1.
- R2: A write to address CFG_ADDR (default 8'hF8) stores wdata bits 0 (external enable), 1 (clock-out disable), 2 (tuning enable) and 7 (long resume delay). A read of CFG_ADDR returns those bits in the same positions, with bits 6..3 reading 0.
- R3: In internal run, a write to CFG_ADDR with bit 0 set causes the following outputs in the next cycle: clk_gate_en_o=0, int_osc_en_o=0, ext_osc_en_o=1, sel_ext_o=1, cpu_run_o=0.
- R4: While halted waiting for the external clock, clk_gate_en_o stays 0 until ext_stable_i is sampled 1. clk_gate_en_o is 1 in the cycle after that sample, and cpu_run_o stays 0.
- R5: With stored bit 7 = 0, cpu_run_o goes to 1 on the clock edge that samples the SHORT_TICKS-th tick_i pulse after the clock gate opens. Before that it stays 0.
- R6: With stored bit 7 = 1, the same release happens on the LONG_TICKS-th tick_i pulse.
- R7: In external run, a write to CFG_ADDR that clears bit 0 leaves sel_ext_o=1, ext_osc_en_o=1 and cpu_run_o=1.
- R8: In either run state, a suspend_req_i pulse sets clk_gate_en_o, cpu_run_o, int_osc_en_o and ext_osc_en_o to 0. A following wake_i pulse restores internal run if stored bit 0 is 0. If stored bit 0 is 1, the wake starts the halted external start-up instead.
- R9: In internal run, osc_out_o is 1 when stored bit 1 is 1 and follows int_clk_i when stored bit 1 is 0. In every other state osc_out_o is 0.
- R10: A read of PORT2_ADDR (default 8'h02) returns osc_in_i in bit 1 during internal run and 0 otherwise. All other bits of that read are 0.
- R11: If ext_stable_i has not been seen within TIMEOUT_CYC cycles of entering the start-up wait, timeout_o becomes 1 and the CPU stays halted. timeout_o then holds until reset.
- R12: Register writes during the start-up wait or the resume delay update the stored bits but do not restart the sequence or release the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ext_stable_i | input | 1 | External oscillator is stable |
| suspend_req_i | input | 1 | Enter suspend pulse |
| wake_i | input | 1 | Wake-from-suspend pulse |
| tick_i | input | 1 | One-microsecond tick pulse |
| int_clk_i | input | 1 | Internal oscillator level for the output pin |
| osc_in_i | input | 1 | Level on the oscillator input pin |
| sel_ext_o | output | 1 | Clock mux selects the external source |
| clk_gate_en_o | output | 1 | Chip clock gate enable |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| ext_osc_en_o | output | 1 | External oscillator enable |
| cpu_run_o | output | 1 | CPU released to run |
| osc_out_o | output | 1 | Level driven on the oscillator output pin |
| timeout_o | output | 1 | Sticky start-up timeout flag |

## Verification
The bench builds the block with SHORT_TICKS=4, LONG_TICKS=10 and TIMEOUT_CYC=20, in place of 128, 4000 and a long timeout. With these values both resume delays and the start-up timeout can be checked exactly at their boundaries. It checks one tick or cycle before each limit and again at the limit. The short and long delays are selected in separate passes of the switch. A wake with the enable bit set is what leads into the timeout case.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    ST_INT_RUN   = 3'd0,
    ST_HALT_WAIT = 3'd1,
    ST_RESUME    = 3'd2,
    ST_EXT_RUN   = 3'd3,
    ST_SUSPEND   = 3'd4
  } clk_state_e;

  typedef struct packed {
    logic long_dly;
    logic tune_en;
    logic clk_out_dis;
    logic ext_en;
  } clk_cfg_t;

endpackage

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs
  import clk_src_pkg::*;
#(
  parameter logic [7:0] CFG_ADDR   = 8'hF8,
  parameter logic [7:0] PORT2_ADDR = 8'h02
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       int_mode_i,
  input  logic       pin_in_i,
  output clk_cfg_t   cfg_o,
  output logic       ext_wr_o,
  output logic [7:0] rdata_o
);

  logic     cfg_hit_wr;
  clk_cfg_t cfg_q;
  logic     unused_wdata;

  assign cfg_hit_wr   = wr_en_i && (addr_i == CFG_ADDR);
  assign ext_wr_o     = cfg_hit_wr && wdata_i[0];
  assign unused_wdata = ^wdata_i[6:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_hit_wr) begin
      cfg_q.ext_en      <= wdata_i[0];
      cfg_q.clk_out_dis <= wdata_i[1];
      cfg_q.tune_en     <= wdata_i[2];
      cfg_q.long_dly    <= wdata_i[7];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_ADDR) begin
      rdata_o[0] = cfg_q.ext_en;
      rdata_o[1] = cfg_q.clk_out_dis;
      rdata_o[2] = cfg_q.tune_en;
      rdata_o[7] = cfg_q.long_dly;
    end else if (addr_i == PORT2_ADDR) begin
      rdata_o[1] = int_mode_i && pin_in_i;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/clk_evt_counter.sv
module clk_evt_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q >= (limit_i - W'(1)));
  assign done_o  = step_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i && !at_last) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/clk_src_fsm.sv
module clk_src_fsm
  import clk_src_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_wr_i,
  input  logic       cfg_ext_i,
  input  logic       stable_i,
  input  logic       suspend_i,
  input  logic       wake_i,
  input  logic       dly_done_i,
  input  logic       to_done_i,
  output clk_state_e state_o,
  output logic       timeout_o,
  output logic       sel_ext_o,
  output logic       gate_en_o,
  output logic       int_osc_en_o,
  output logic       ext_osc_en_o,
  output logic       cpu_run_o
);

  clk_state_e state_q, state_d;
  logic       timeout_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INT_RUN: begin
        if (suspend_i)     state_d = ST_SUSPEND;
        else if (ext_wr_i) state_d = ST_HALT_WAIT;
      end
      ST_HALT_WAIT: if (stable_i)   state_d = ST_RESUME;
      ST_RESUME:    if (dly_done_i) state_d = ST_EXT_RUN;
      ST_EXT_RUN:   if (suspend_i)  state_d = ST_SUSPEND;
      ST_SUSPEND:   if (wake_i)     state_d = cfg_ext_i ? ST_HALT_WAIT : ST_INT_RUN;
      default:      state_d = ST_INT_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INT_RUN;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_HALT_WAIT && to_done_i && !stable_i) timeout_q <= 1'b1;
    end
  end

  always_comb begin
    sel_ext_o    = 1'b0;
    gate_en_o    = 1'b0;
    int_osc_en_o = 1'b0;
    ext_osc_en_o = 1'b0;
    cpu_run_o    = 1'b0;
    unique case (state_q)
      ST_INT_RUN: begin
        gate_en_o    = 1'b1;
        int_osc_en_o = 1'b1;
        cpu_run_o    = 1'b1;
      end
      ST_HALT_WAIT: begin
        sel_ext_o    = 1'b1;
        ext_osc_en_o = 1'b1;
      end
      ST_RESUME: begin
        sel_ext_o    = 1'b1;
        ext_osc_en_o = 1'b1;
        gate_en_o    = 1'b1;
      end
      ST_EXT_RUN: begin
        sel_ext_o    = 1'b1;
        ext_osc_en_o = 1'b1;
        gate_en_o    = 1'b1;
        cpu_run_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o   = state_q;
  assign timeout_o = timeout_q;

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter logic [7:0] CFG_ADDR    = 8'hF8,
  parameter logic [7:0] PORT2_ADDR  = 8'h02,
  parameter int         SHORT_TICKS = 128,
  parameter int         LONG_TICKS  = 4000,
  parameter int         TIMEOUT_CYC = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       ext_stable_i,
  input  logic       suspend_req_i,
  input  logic       wake_i,
  input  logic       tick_i,
  input  logic       int_clk_i,
  input  logic       osc_in_i,
  output logic       sel_ext_o,
  output logic       clk_gate_en_o,
  output logic       int_osc_en_o,
  output logic       ext_osc_en_o,
  output logic       cpu_run_o,
  output logic       osc_out_o,
  output logic       timeout_o
);

  localparam int DLY_MAX = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int DW      = $clog2(DLY_MAX + 1);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);

  clk_state_e state;
  clk_cfg_t   cfg;
  logic       ext_wr;
  logic       int_mode;
  logic       dly_done;
  logic       to_done;
  logic [DW-1:0] dly_limit;

  assign int_mode  = (state == ST_INT_RUN);
  assign dly_limit = cfg.long_dly ? DW'(LONG_TICKS) : DW'(SHORT_TICKS);

  clk_cfg_regs #(
    .CFG_ADDR  (CFG_ADDR),
    .PORT2_ADDR(PORT2_ADDR)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .int_mode_i(int_mode),
    .pin_in_i  (osc_in_i),
    .cfg_o     (cfg),
    .ext_wr_o  (ext_wr),
    .rdata_o   (rdata_o)
  );

  clk_evt_counter #(.W(DW)) i_dly_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_RESUME),
    .step_i (tick_i),
    .limit_i(dly_limit),
    .done_o (dly_done)
  );

  clk_evt_counter #(.W(TW)) i_to_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_HALT_WAIT),
    .step_i (1'b1),
    .limit_i(TW'(TIMEOUT_CYC)),
    .done_o (to_done)
  );

  clk_src_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_wr_i    (ext_wr),
    .cfg_ext_i   (cfg.ext_en),
    .stable_i    (ext_stable_i),
    .suspend_i   (suspend_req_i),
    .wake_i      (wake_i),
    .dly_done_i  (dly_done),
    .to_done_i   (to_done),
    .state_o     (state),
    .timeout_o   (timeout_o),
    .sel_ext_o   (sel_ext_o),
    .gate_en_o   (clk_gate_en_o),
    .int_osc_en_o(int_osc_en_o),
    .ext_osc_en_o(ext_osc_en_o),
    .cpu_run_o   (cpu_run_o)
  );

  assign osc_out_o = int_mode && (cfg.clk_out_dis || int_clk_i);

endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk #(
  parameter logic [7:0] CFG_ADDR   = 8'hF8,
  parameter logic [7:0] PORT2_ADDR = 8'h02
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       ext_stable_i,
  input logic       suspend_req_i,
  input logic       tick_i,
  input logic       sel_ext_o,
  input logic       clk_gate_en_o,
  input logic       int_osc_en_o,
  input logic       ext_osc_en_o,
  input logic       cpu_run_o,
  input logic       osc_out_o,
  input logic       timeout_o
);

  assert_osc_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_osc_en_o && ext_osc_en_o));

  assert_switch_halts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ext_o && cpu_run_o && !suspend_req_i && wr_en_i && addr_i == CFG_ADDR && wdata_i[0])
    |=> (!cpu_run_o && !clk_gate_en_o && ext_osc_en_o && !int_osc_en_o));

  assert_gate_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_osc_en_o && !clk_gate_en_o && !ext_stable_i) |=> !clk_gate_en_o);

  assert_no_tick_no_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_gate_en_o && !cpu_run_o && !tick_i) |=> !cpu_run_o);

  assert_ext_one_way_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ext_o && cpu_run_o && !suspend_req_i) |=> (sel_ext_o && cpu_run_o));

  assert_pin_low_ext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ext_o |-> !osc_out_o);

  assert_port2_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ext_o && addr_i == PORT2_ADDR) |-> (rdata_o == 8'h00));

  assert_timeout_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

endmodule

bind clk_src_ctrl clk_src_ctrl_chk #(
  .CFG_ADDR  (CFG_ADDR),
  .PORT2_ADDR(PORT2_ADDR)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .ext_stable_i (ext_stable_i),
  .suspend_req_i(suspend_req_i),
  .tick_i       (tick_i),
  .sel_ext_o    (sel_ext_o),
  .clk_gate_en_o(clk_gate_en_o),
  .int_osc_en_o (int_osc_en_o),
  .ext_osc_en_o (ext_osc_en_o),
  .cpu_run_o    (cpu_run_o),
  .osc_out_o    (osc_out_o),
  .timeout_o    (timeout_o)
);

// File: tb/test_clk_src_ctrl.sv
`timescale 1ns/1ps
module test_clk_src_ctrl;

  localparam logic [7:0] CFG_A  = 8'hF8;
  localparam logic [7:0] P2_A   = 8'h02;
  localparam int         SHORT  = 4;
  localparam int         LONG   = 10;
  localparam int         TO_CYC = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       ext_stable_i = 1'b0;
  logic       suspend_req_i = 1'b0;
  logic       wake_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       int_clk_i = 1'b0;
  logic       osc_in_i = 1'b0;
  logic       sel_ext_o, clk_gate_en_o, int_osc_en_o, ext_osc_en_o;
  logic       cpu_run_o, osc_out_o, timeout_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  clk_src_ctrl #(
    .CFG_ADDR   (CFG_A),
    .PORT2_ADDR (P2_A),
    .SHORT_TICKS(SHORT),
    .LONG_TICKS (LONG),
    .TIMEOUT_CYC(TO_CYC)
  ) i_clk_src_ctrl (.*);

  // wdata, int_clk, osc_in, exp cfg read, exp osc_out, exp port2 read
  typedef struct packed {
    logic [7:0] wdata;
    logic       clk_lvl;
    logic       pin_lvl;
    logic [7:0] exp_cfg;
    logic       exp_out;
    logic [7:0] exp_p2;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hFE, 1'b0, 1'b1, 8'h86, 1'b1, 8'h02},
    '{8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00},
    '{8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 8'h02},
    '{8'h84, 1'b1, 1'b1, 8'h84, 1'b1, 8'h02},
    '{8'h7C, 1'b0, 1'b0, 8'h04, 1'b0, 8'h00},
    '{8'h02, 1'b0, 1'b0, 8'h02, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr_i = a; #1;
    chk(req, "read", {24'h0, rdata_o}, {24'h0, exp});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1; step(); tick_i = 1'b0;
    end
  endtask

  task automatic pulse_stable();
    ext_stable_i = 1'b1; step(); ext_stable_i = 1'b0;
  endtask

  task automatic pulse_suspend();
    suspend_req_i = 1'b1; step(); suspend_req_i = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_i = 1'b1; step(); wake_i = 1'b0;
  endtask

  // {sel_ext, gate, int_osc, ext_osc, cpu_run}
  function automatic logic [31:0] outs();
    return {27'h0, sel_ext_o, clk_gate_en_o, int_osc_en_o, ext_osc_en_o, cpu_run_o};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1", "outputs", outs(), 32'b01101);
    chk("R1", "timeout", {31'h0, timeout_o}, 32'h0);
    rd("R1", CFG_A, 8'h00);

    // R2, R9, R10 vector walk in internal run
    foreach (VECS[i]) begin
      wr(CFG_A, VECS[i].wdata);
      int_clk_i = VECS[i].clk_lvl;
      osc_in_i  = VECS[i].pin_lvl;
      rd("R2", CFG_A, VECS[i].exp_cfg);
      chk("R9", "osc_out", {31'h0, osc_out_o}, {31'h0, VECS[i].exp_out});
      rd("R10", P2_A, VECS[i].exp_p2);
    end
    wr(CFG_A, 8'h00);

    // R3 switch request
    osc_in_i = 1'b1; int_clk_i = 1'b1;
    wr(CFG_A, 8'h01);
    chk("R3", "halt outputs", outs(), 32'b10010);
    rd("R2", CFG_A, 8'h01);
    rd("R10", P2_A, 8'h00);
    chk("R9", "osc_out ext", {31'h0, osc_out_o}, 32'h0);

    // R4 wait for stable; R12 write during wait
    repeat (3) step();
    chk("R4", "still gated", outs(), 32'b10010);
    wr(CFG_A, 8'h00);
    chk("R12", "write in wait", outs(), 32'b10010);
    rd("R12", CFG_A, 8'h00);
    pulse_stable();
    chk("R4", "gate open", outs(), 32'b11010);

    // R5 short delay
    ticks(SHORT - 1);
    chk("R5", "before short", {31'h0, cpu_run_o}, 32'h0);
    ticks(1);
    chk("R5", "at short", outs(), 32'b11011);

    // R7 one-way
    wr(CFG_A, 8'h02);
    step();
    chk("R7", "clear ignored", outs(), 32'b11011);

    // R8 suspend then wake to internal
    pulse_suspend();
    chk("R8", "suspended", outs(), 32'b00000);
    pulse_wake();
    chk("R8", "wake internal", outs(), 32'b01101);

    // R6 long delay, R12 write during resume
    wr(CFG_A, 8'h81);
    pulse_stable();
    ticks(LONG - 3);
    wr(CFG_A, 8'h81);
    chk("R12", "write in resume", outs(), 32'b11010);
    ticks(2);
    chk("R6", "before long", {31'h0, cpu_run_o}, 32'h0);
    ticks(1);
    chk("R6", "at long", outs(), 32'b11011);

    // R8 wake with bit 0 set
    pulse_suspend();
    pulse_wake();
    chk("R8", "wake external", outs(), 32'b10010);

    // R11 timeout
    repeat (TO_CYC - 1) step();
    chk("R11", "before timeout", {31'h0, timeout_o}, 32'h0);
    step();
    chk("R11", "timeout set", {31'h0, timeout_o}, 32'h1);
    repeat (5) step();
    chk("R11", "still halted", outs(), 32'b10010);
    pulse_stable();
    chk("R11", "sticky", {31'h0, timeout_o}, 32'h1);
    rst_ni = 1'b0; #1;
    chk("R11", "cleared by reset", {31'h0, timeout_o}, 32'h0);
    chk("R1", "reset outputs", outs(), 32'b01101);
    step();
    rst_ni = 1'b1;
    step();
    finish_run();
  end

endmodule